// File: doc/BRIEF.md
# Double-Buffered Clock/Calendar Register Bank

This block keeps time of day and date in two copies. A hidden working copy counts seconds, minutes, hours, day of month, month and two-digit year in BCD. It moves forward one second after every `PRESCALE_DIV` pulses of `base_tick`, but only while the run bit is set. A second copy is the one the host sees. While the hold bit is clear, that visible copy follows the working copy with a lag of one cycle.

The host reaches the block over a chip-select, output-enable and write-enable bus with a 5-bit address and 8-bit data. All of these inputs are sampled on `clk`. Setting the hold bit freezes the visible copy, so the host can read a snapshot that does not change between bytes while the working copy keeps counting. While hold is set, the host may also write new time values into the visible copy. Clearing hold then loads those values into the working copy and restarts the prescaler. The data bus is split into an input, an output and a drive-enable, so that a pad ring or a tristate wrapper can rebuild the shared bus.

Top module: `rtc_dual_bank`

## Requirements
- R1: After reset, the registers read as follows: seconds (address 0) = 0x00, minutes (1) = 0x00, hours (2) = 0x00, day (3) = 0x01, month (4) = 0x01, year (5) = 0x00, control (7) = 0x00. Control bit 0 is hold and bit 1 is run. Address 6 and addresses 8 to 31 always read 0x00.
- R2: A clock edge that samples `cs_n`=0, `oe_n`=0 and `we_n`=1 makes `dq_oe` 1 and puts the addressed register on `dq_out` after that edge. Otherwise `dq_out` reads 0x00.
- R3: After any edge without that read condition, `dq_oe` is 0. This covers `cs_n` high (standby), both enables high, and `we_n` falling while `oe_n` is already low.
- R4: A write happens at the first edge where `cs_n` and `we_n` are both low. Holding both low for more cycles does not write again, even if `dq_in` changes.
- R5: With run=1, the working time advances one second per `PRESCALE_DIV` (default 4) `base_tick` pulses. With run=0, it does not advance.
- R6: While hold=0, the visible time registers take the working time one cycle later.
- R7: While hold=1, the visible time registers stay static and the working time keeps advancing. That advance becomes visible after hold is cleared.
- R8: A host write to addresses 0 to 5 takes effect only while hold=1. With hold=0, the write has no effect.
- R9: Clearing hold after at least one time write loads the visible values into the working set and clears the prescaler. A `base_tick` pulse in that same cycle is discarded.
- R10: The counters roll over after 59 seconds, 59 minutes, 23 hours, month 12 and year 99. Day and month wrap back to 01.
- R11: Day rolls over after 30 for months 04, 06, 09 and 11, and after 31 for the other months except February. February has 29 days when the year is divisible by 4, otherwise 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Single-cycle prescaler enable pulse |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 5 | Register address |
| dq_in | input | 8 | Write data from host |
| dq_out | output | 8 | Read data to host |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The release of hold can land in the same cycle as the prescaler's last `base_tick` of a second. The commit must win, and the second that would have elapsed is lost. To provoke this, the bench moves the prescaler to its final count, freezes, writes a new seconds value, and then issues the control write that clears hold together with a tick. The result is judged from the seconds value that can be read after further counted ticks. A behavioural model in the bench also tracks both register sets and the prescaler phase. On every clock it compares the model's predicted bus outputs with those of the design.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam int CTL_HOLD_BIT = 0;
    localparam int CTL_RUN_BIT  = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC  = 5'd0,
        REG_MIN  = 5'd1,
        REG_HOUR = 5'd2,
        REG_DAY  = 5'd3,
        REG_MON  = 5'd4,
        REG_YEAR = 5'd5,
        REG_CTL  = 5'd7
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] year_bcd);
        logic [6:0] yb;
        yb = bcd_to_bin(year_bcd);
        return yb[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
        case (mon)
            8'h02:                      return year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_reset();
        rtc_time_t t;
        t.sec  = 8'h00;
        t.min  = 8'h00;
        t.hour = 8'h00;
        t.day  = 8'h01;
        t.mon  = 8'h01;
        t.year = 8'h00;
        return t;
    endfunction

    function automatic rtc_time_t time_next(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) begin
                n.min = bcd_inc(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hour != 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    if (t.day != last_day(t.mon, t.year)) begin
                        n.day = bcd_inc(t.day);
                    end else begin
                        n.day = 8'h01;
                        if (t.mon != 8'h12) begin
                            n.mon = bcd_inc(t.mon);
                        end else begin
                            n.mon  = 8'h01;
                            n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic base_tick,
    input  logic clr,
    output logic sec_step
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && base_tick) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sec_step = run && base_tick && !clr && (cnt_q == LAST);

    // R5: phase counter never leaves its range
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R9: a cleared prescaler starts from phase zero
    a_r9_clear_phase: assert property (@(posedge clk) disable iff (rst)
        (!rst && clr) |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cur
);
    rtc_time_t cur_q;

    always_ff @(posedge clk) begin
        if (rst)       cur_q <= time_reset();
        else if (load) cur_q <= load_val;
        else if (step) cur_q <= time_next(cur_q);
    end

    assign cur = cur_q;

    // R5: without a step or a load the working time does not move
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!rst && !step && !load) |=> $stable(cur_q));

    // R10: seconds wrap from 59 to 00
    a_r10_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (!rst && step && !load && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  rtc_time_t         int_time,
    output rtc_time_t         ext_time,
    output logic              run,
    output logic              commit,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic      wr_prev_q, hold_q, run_q, dirty_q;
    rtc_time_t ext_q;
    logic      wr_act, wr_pulse, rd_act, ctl_wr, hold_nx, time_wr;
    logic [DATA_W-1:0] rd_val;

    assign wr_act   = !cs_n && !we_n;
    assign wr_pulse = wr_act && !wr_prev_q;
    assign rd_act   = !cs_n && !oe_n && we_n;
    assign ctl_wr   = wr_pulse && (addr == REG_CTL);
    assign hold_nx  = ctl_wr ? din[CTL_HOLD_BIT] : hold_q;
    assign commit   = hold_q && !hold_nx && dirty_q;
    assign time_wr  = wr_pulse && hold_q && (addr <= REG_YEAR);

    always_comb begin
        case (addr)
            REG_SEC:  rd_val = ext_q.sec;
            REG_MIN:  rd_val = ext_q.min;
            REG_HOUR: rd_val = ext_q.hour;
            REG_DAY:  rd_val = ext_q.day;
            REG_MON:  rd_val = ext_q.mon;
            REG_YEAR: rd_val = ext_q.year;
            REG_CTL:  rd_val = {6'd0, run_q, hold_q};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev_q <= 1'b0;
            hold_q    <= 1'b0;
            run_q     <= 1'b0;
            dirty_q   <= 1'b0;
            ext_q     <= time_reset();
            dq_oe     <= 1'b0;
            dq_out    <= '0;
        end else begin
            wr_prev_q <= wr_act;
            if (ctl_wr) begin
                hold_q <= din[CTL_HOLD_BIT];
                run_q  <= din[CTL_RUN_BIT];
            end
            if (commit)       dirty_q <= 1'b0;
            else if (time_wr) dirty_q <= 1'b1;
            if (!hold_q) begin
                ext_q <= int_time;
            end else if (time_wr) begin
                case (addr)
                    REG_SEC:  ext_q.sec  <= din;
                    REG_MIN:  ext_q.min  <= din;
                    REG_HOUR: ext_q.hour <= din;
                    REG_DAY:  ext_q.day  <= din;
                    REG_MON:  ext_q.mon  <= din;
                    default:  ext_q.year <= din;
                endcase
            end
            dq_oe  <= rd_act;
            dq_out <= rd_act ? rd_val : '0;
        end
    end

    assign ext_time = ext_q;
    assign run      = run_q;

    // R2: a sampled read cycle turns the drivers on
    a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cs_n && !oe_n && we_n) |=> dq_oe);

    // R3: write enable low keeps the drivers off
    a_r3_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!rst && !we_n) |=> !dq_oe);

    // R7: frozen visible set changes only through a host write
    a_r7_hold_static: assert property (@(posedge clk) disable iff (rst)
        (!rst && hold_q && !time_wr) |=> $stable(ext_q));

    // R6: open visible set mirrors the working time one cycle later
    a_r6_follow: assert property (@(posedge clk) disable iff (rst)
        (!rst && !hold_q) |=> (ext_q == $past(int_time)));

endmodule

// File: rtl/rtc_dual_bank.sv
module rtc_dual_bank
    import rtc_bank_pkg::*;
#(
    parameter int PRESCALE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       cs_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic [4:0] addr,
    input  logic [7:0] dq_in,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    rtc_time_t int_time, ext_time;
    logic      run, commit, sec_step;

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .base_tick (base_tick),
        .clr       (commit),
        .sec_step  (sec_step)
    );

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .step     (sec_step),
        .load     (commit),
        .load_val (ext_time),
        .cur      (int_time)
    );

    rtc_host_port u_port (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (dq_in),
        .int_time (int_time),
        .ext_time (ext_time),
        .run      (run),
        .commit   (commit),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: tb/test_rtc_dual_bank.sv
`timescale 1ns/1ps
module test_rtc_dual_bank;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_dual_bank #(.PRESCALE_DIV(DIV)) i_rtc_dual_bank (
        .clk(clk), .rst(rst), .base_tick(base_tick),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- behavioural reference model ----------------
    int       ms, mm, mh, md, mmo, my, m_pre;
    bit       m_hold, m_run, m_dirty, m_wrprev, m_oe;
    bit [7:0] m_ext [6];
    bit [7:0] m_dout;

    function automatic bit [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(bit [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0; md++;
                    if (md > mdays(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo > 12) begin
                            mmo = 1; my++;
                            if (my > 99) my = 0;
                        end
                    end
                end
            end
        end
    endtask

    function automatic bit [7:0] model_read(bit [4:0] a);
        if (a <= 5) return m_ext[a];
        if (a == 7) return {6'd0, m_run, m_hold};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; m_pre = 0;
            m_hold = 0; m_run = 0; m_dirty = 0; m_wrprev = 0;
            m_oe = 0; m_dout = 0;
            m_ext[0] = 8'h00; m_ext[1] = 8'h00; m_ext[2] = 8'h00;
            m_ext[3] = 8'h01; m_ext[4] = 8'h01; m_ext[5] = 8'h00;
        end else begin
            bit wa, wp, ra, ctlw, hold_n, run_n, cmt, tw;
            bit [7:0] oldint [6];
            wa = !cs_n && !we_n;
            wp = wa && !m_wrprev;
            m_wrprev = wa;
            ra = !cs_n && !oe_n && we_n;
            ctlw = wp && addr == 5'd7;
            hold_n = ctlw ? dq_in[0] : m_hold;
            run_n  = ctlw ? dq_in[1] : m_run;
            cmt = m_hold && !hold_n && m_dirty;
            tw = wp && m_hold && addr <= 5'd5;
            m_oe = ra;
            m_dout = ra ? model_read(addr) : 8'h00;
            oldint[0] = to_bcd(ms); oldint[1] = to_bcd(mm); oldint[2] = to_bcd(mh);
            oldint[3] = to_bcd(md); oldint[4] = to_bcd(mmo); oldint[5] = to_bcd(my);
            if (cmt) begin
                ms = from_bcd(m_ext[0]); mm = from_bcd(m_ext[1]); mh = from_bcd(m_ext[2]);
                md = from_bcd(m_ext[3]); mmo = from_bcd(m_ext[4]); my = from_bcd(m_ext[5]);
                m_pre = 0;
            end else if (m_run && base_tick) begin
                if (m_pre == DIV - 1) begin
                    m_pre = 0;
                    model_second();
                end else begin
                    m_pre++;
                end
            end
            if (!m_hold) begin
                for (int i = 0; i < 6; i++) m_ext[i] = oldint[i];
            end else if (tw) begin
                m_ext[addr] = dq_in;
            end
            if (cmt)     m_dirty = 0;
            else if (tw) m_dirty = 1;
            m_hold = hold_n;
            m_run  = run_n;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (dq_oe !== m_oe) begin
                fails++;
                $display("FAIL R3 cycle compare dq_oe: got %0b expected %0b", dq_oe, m_oe);
            end
            tests++;
            if (dq_out !== m_dout) begin
                fails++;
                $display("FAIL R2 cycle compare dq_out: got %02h expected %02h", dq_out, m_dout);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(bit [4:0] a, bit [7:0] d);
        @(negedge clk);
        cs_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
        @(negedge clk);
        cs_n = 1; we_n = 1;
    endtask

    task automatic rd(bit [4:0] a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk);
        v = dq_out;
        cs_n = 1; oe_n = 1;
    endtask

    task automatic pulses(int n);
        repeat (n) begin
            @(negedge clk);
            base_tick = 1;
        end
        @(negedge clk);
        base_tick = 0;
    endtask

    task automatic set_time(bit [7:0] s, bit [7:0] mi, bit [7:0] h,
                            bit [7:0] d, bit [7:0] mo, bit [7:0] y);
        wr(5'd7, 8'h03);
        wr(5'd0, s); wr(5'd1, mi); wr(5'd2, h);
        wr(5'd3, d); wr(5'd4, mo); wr(5'd5, y);
        wr(5'd7, 8'h02);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [7:0] v, v0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset map
        rd(5'd0, v); check("R1 sec", v, 8'h00);
        rd(5'd1, v); check("R1 min", v, 8'h00);
        rd(5'd2, v); check("R1 hour", v, 8'h00);
        rd(5'd3, v); check("R1 day", v, 8'h01);
        rd(5'd4, v); check("R1 month", v, 8'h01);
        rd(5'd5, v); check("R1 year", v, 8'h00);
        rd(5'd7, v); check("R1 control", v, 8'h00);
        rd(5'd6, v); check("R1 unused 6", v, 8'h00);
        rd(5'd20, v); check("R1 unused 20", v, 8'h00);

        // R5 no advance while stopped, then count
        pulses(12);
        rd(5'd0, v); check("R5 stopped", v, 8'h00);
        wr(5'd7, 8'h02);
        pulses(12);
        rd(5'd0, v); check("R5 three seconds", v, 8'h03);

        // R7 frozen snapshot while working time runs
        wr(5'd7, 8'h03);
        pulses(8);
        rd(5'd0, v); check("R7 frozen", v, 8'h03);
        wr(5'd7, 8'h02);
        rd(5'd0, v); check("R7 ran underneath", v, 8'h05);

        // R8 write with hold clear has no effect
        wr(5'd0, 8'h45);
        rd(5'd0, v); check("R8 ignored write", v, 8'h05);

        // R4 only the first cycle of a long write counts
        wr(5'd7, 8'h03);
        @(negedge clk);
        cs_n = 0; we_n = 0; oe_n = 1; addr = 5'd0; dq_in = 8'h33;
        @(negedge clk); dq_in = 8'h44;
        @(negedge clk); dq_in = 8'h55;
        @(negedge clk); cs_n = 1; we_n = 1;
        rd(5'd0, v); check("R4 single capture", v, 8'h33);
        wr(5'd7, 8'h02);

        // R10 full rollover
        set_time(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
        pulses(2 * DIV);
        rd(5'd0, v); check("R10 sec", v, 8'h00);
        rd(5'd1, v); check("R10 min", v, 8'h00);
        rd(5'd2, v); check("R10 hour", v, 8'h00);
        rd(5'd3, v); check("R10 day", v, 8'h01);
        rd(5'd4, v); check("R10 month", v, 8'h01);
        rd(5'd5, v); check("R10 year", v, 8'h00);

        // R11 leap and month lengths
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
        pulses(DIV);
        rd(5'd3, v); check("R11 leap day", v, 8'h29);
        rd(5'd4, v); check("R11 leap month", v, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
        pulses(DIV);
        rd(5'd3, v); check("R11 common day", v, 8'h01);
        rd(5'd4, v); check("R11 common month", v, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23);
        pulses(DIV);
        rd(5'd3, v); check("R11 30-day day", v, 8'h01);
        rd(5'd4, v); check("R11 30-day month", v, 8'h05);

        // R9 commit coincides with the last tick of a second
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        pulses(DIV - 1);
        wr(5'd7, 8'h03);
        wr(5'd0, 8'h20);
        @(negedge clk);
        cs_n = 0; we_n = 0; oe_n = 1; addr = 5'd7; dq_in = 8'h02; base_tick = 1;
        @(negedge clk);
        cs_n = 1; we_n = 1; base_tick = 0;
        pulses(DIV - 1);
        rd(5'd0, v); check("R9 tick discarded", v, 8'h20);
        pulses(1);
        rd(5'd0, v); check("R6 visible follows", v, 8'h21);

        // R2 / R3 drive control
        @(negedge clk);
        cs_n = 0; oe_n = 0; we_n = 1; addr = 5'd7;
        @(negedge clk);
        check("R2 drive on read", {7'd0, dq_oe}, 8'h01);
        v0 = dq_out;
        check("R2 control readback", v0, 8'h02);
        we_n = 0; dq_in = 8'h02;
        @(negedge clk);
        check("R3 we falls with oe low", {7'd0, dq_oe}, 8'h00);
        we_n = 1; oe_n = 1;
        @(negedge clk);
        check("R3 enables high", {7'd0, dq_oe}, 8'h00);
        cs_n = 1; oe_n = 0;
        @(negedge clk);
        check("R3 standby", {7'd0, dq_oe}, 8'h00);
        oe_n = 1;
        repeat (3) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule